// File: doc/BRIEF.md
# PS/2 host interface register block

This block is the processor-facing front end of a PS/2 keyboard or mouse port. It sits on a simple word-addressed register bus. Behind the bus it keeps a small set of registers: control, status, data, clock divisor and interrupt status. The top eight words of its 4 KB window are a read-only identification area. Received bytes arrive from a separate byte-level PS/2 receiver over a valid/ready handshake. Bytes written by the host leave towards a separate transmitter as a one-cycle strobe. The bit-level line serialiser and the divisor-driven timing sit outside this block. The divisor value is only stored here for them.

Reception is held one byte deep. An incoming byte is taken only while nothing is pending. Reading the data register moves the pending byte into the last-byte register and returns it. A read with nothing pending returns the last byte again. One level-sensitive interrupt line is formed from the pending flag and two control bits.

Bus protocol: a request is one cycle with `bus_sel` high. `bus_wr` selects a write. `bus_addr` is a byte address, and its two low bits are ignored. The read result appears on `bus_rdata` after the next rising clock edge.

Top module: `ps2_host_regs`

## Requirements
- R1: After synchronous reset the following are all zero: control, clock divisor, last byte, pending flag, `tx_valid`, `irq` and `bus_rdata`. `rx_ready` is high.
- R2: Word 0 (offset 0x00) is control and word 3 (offset 0x0C) is clock divisor. Each is read/write storage of 8 bits, and its upper read bits are zero. Read data is registered, one cycle after the request.
- R3: A byte is accepted when `rx_valid` and `rx_ready` are both high. Acceptance sets the pending flag. `rx_ready` is low whenever a byte is pending, so a byte offered while one is pending is not taken.
- R4: A read of word 2 (offset 0x08) while pending returns the held byte, makes it the last byte and clears pending. A read with nothing pending returns the last byte unchanged.
- R5: A read of word 1 (offset 0x04) returns the status word. Bit6 is 1 (transmit empty). Bit5 is `tx_busy`. Bit4 is the pending flag. Bit3 is `rx_busy`. Bit2 is receive parity. Bit1 is `line_clk`. Bit0 is `line_dat`. All other bits are 0.
- R6: Status bit2 equals the XOR of the eight bits of the last byte.
- R7: `irq` is high exactly when control bit3 is set, or when control bit4 is set and a byte is pending. It follows a control write in the cycle after that write.
- R8: A read of word 4 (offset 0x10) returns bit0 = pending flag and bit1 = 1. All other bits are 0.
- R9: Offsets 0xFE0, 0xFE4, … 0xFFC read as 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in ascending order, in bits 7:0, with upper bits zero.
- R10: A write to the data word raises `tx_valid` for exactly one cycle after the write, with `tx_data` equal to write data bits 7:0. No other access raises `tx_valid`.
- R11: Reads of unmapped offsets return zero. Writes to the status word, the interrupt status word, the identification area and unmapped offsets change no state and raise no `tx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address within the window |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| rx_valid | input | 1 | Receiver offers a byte |
| rx_data | input | 8 | Offered byte |
| rx_ready | output | 1 | Block can take a byte |
| rx_busy | input | 1 | Receiver mid-frame, reported in status |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_data | output | 8 | Byte to transmit |
| tx_busy | input | 1 | Transmitter busy, reported in status |
| line_clk | input | 1 | PS/2 clock line level |
| line_dat | input | 1 | PS/2 data line level |
| irq | output | 1 | Level interrupt |

## Verification
The embedded properties check several behaviours on every cycle:
- an accepted byte becomes pending with the offered value;
- a pending-data read pops it into the last-byte register;
- an idle data read leaves the last byte alone;
- each data write produces its strobe with the low byte;
- the interrupt stays low without its causes;
- identification reads carry zero upper bits.

Other behaviours only show in the bench's scenarios:
- the exact bit layout of status and interrupt status;
- the parity value over many bytes;
- the identification byte order;
- the loss of a byte offered while one is pending;
- the absence of side effects from writes to read-only and unmapped offsets.

// File: rtl/ps2h_pkg.sv
package ps2h_pkg;
  localparam int W_CTRL  = 0;
  localparam int W_STAT  = 1;
  localparam int W_DATA  = 2;
  localparam int W_CDIV  = 3;
  localparam int W_ISTAT = 4;
  localparam int ID_WORDS = 8;

  typedef struct packed {
    logic tx_empty;
    logic tx_busy;
    logic rx_full;
    logic rx_busy;
    logic rx_par;
    logic ln_clk;
    logic ln_dat;
  } stat_t;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h50;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/ps2h_rx_hold.sv
module ps2h_rx_hold (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       rx_ready,
  input  logic       pop,
  output logic       pending,
  output logic [7:0] hold,
  output logic [7:0] last,
  output logic       parity
);
  logic accept;

  assign rx_ready = !pending;
  assign accept   = rx_valid && rx_ready;
  assign parity   = ^last;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      hold    <= '0;
      last    <= '0;
    end else begin
      if (accept) begin
        pending <= 1'b1;
        hold    <= rx_data;
      end else if (pop && pending) begin
        pending <= 1'b0;
        last    <= hold;
      end
    end
  end

  AST_ACCEPT_SETS_PENDING: assert property (@(posedge clk) disable iff (rst)
    rx_valid && rx_ready |=> pending && hold == $past(rx_data)); // R3
  AST_POP_MOVES_BYTE: assert property (@(posedge clk) disable iff (rst)
    pop && pending |=> !pending && last == $past(hold)); // R4
  AST_IDLE_POP_KEEPS: assert property (@(posedge clk) disable iff (rst)
    pop && !pending && !rx_valid |=> $stable(last) && !pending); // R4
endmodule

// File: rtl/ps2h_tx_port.sv
module ps2h_tx_port (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_stb,
  input  logic [7:0] wr_byte,
  output logic       tx_valid,
  output logic [7:0] tx_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= wr_stb;
      if (wr_stb) tx_data <= wr_byte;
    end
  end
endmodule

// File: rtl/ps2h_rdmux.sv
module ps2h_rdmux
  import ps2h_pkg::*;
#(
  parameter int WIDX_W = 10,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic [WIDX_W-1:0] widx,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [DIV_W-1:0]  cdiv,
  input  stat_t             stat,
  input  logic              pending,
  input  logic [7:0]        hold,
  input  logic [7:0]        last,
  output logic              id_hit,
  output logic [DATA_W-1:0] rdata_nxt
);
  localparam logic [WIDX_W-1:0] ID_FIRST = WIDX_W'((1 << WIDX_W) - ID_WORDS);

  assign id_hit = widx >= ID_FIRST;

  always_comb begin
    rdata_nxt = '0;
    if (id_hit) begin
      rdata_nxt = DATA_W'(id_byte(widx[2:0]));
    end else begin
      case (widx)
        WIDX_W'(W_CTRL):  rdata_nxt = DATA_W'(ctrl);
        WIDX_W'(W_STAT):  rdata_nxt = DATA_W'(stat);
        WIDX_W'(W_DATA):  rdata_nxt = DATA_W'(pending ? hold : last);
        WIDX_W'(W_CDIV):  rdata_nxt = DATA_W'(cdiv);
        WIDX_W'(W_ISTAT): rdata_nxt = DATA_W'({1'b1, pending});
        default:          rdata_nxt = '0;
      endcase
    end
  end
endmodule

// File: rtl/ps2_host_regs.sv
module ps2_host_regs
  import ps2h_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  input  logic              rx_busy,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_busy,
  input  logic              line_clk,
  input  logic              line_dat,
  output logic              irq
);
  localparam int WIDX_W = ADDR_W - 2;
  localparam int BIT_IRQ_ALWAYS = 3;
  localparam int BIT_IRQ_RX     = 4;

  logic [WIDX_W-1:0] widx;
  logic              rd_req, wr_req, id_hit;
  logic              wr_ctrl, wr_cdiv, wr_data, rd_data;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DIV_W-1:0]  cdiv_q;
  logic              pending, parity;
  logic [7:0]        hold, last;
  logic [DATA_W-1:0] rdata_nxt;
  stat_t             stat;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign rd_req  = bus_sel && !bus_wr;
  assign wr_req  = bus_sel && bus_wr;
  assign wr_ctrl = wr_req && !id_hit && widx == WIDX_W'(W_CTRL);
  assign wr_cdiv = wr_req && !id_hit && widx == WIDX_W'(W_CDIV);
  assign wr_data = wr_req && !id_hit && widx == WIDX_W'(W_DATA);
  assign rd_data = rd_req && !id_hit && widx == WIDX_W'(W_DATA);

  always_comb begin
    stat.tx_empty = 1'b1;
    stat.tx_busy  = tx_busy;
    stat.rx_full  = pending;
    stat.rx_busy  = rx_busy;
    stat.rx_par   = parity;
    stat.ln_clk   = line_clk;
    stat.ln_dat   = line_dat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      cdiv_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (wr_cdiv) cdiv_q <= bus_wdata[DIV_W-1:0];
      if (rd_req)  bus_rdata <= rdata_nxt;
    end
  end

  assign irq = ctrl_q[BIT_IRQ_ALWAYS] || (ctrl_q[BIT_IRQ_RX] && pending);

  ps2h_rx_hold u_rx (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_ready (rx_ready),
    .pop      (rd_data),
    .pending  (pending),
    .hold     (hold),
    .last     (last),
    .parity   (parity)
  );

  ps2h_tx_port u_tx (
    .clk      (clk),
    .rst      (rst),
    .wr_stb   (wr_data),
    .wr_byte  (bus_wdata[7:0]),
    .tx_valid (tx_valid),
    .tx_data  (tx_data)
  );

  ps2h_rdmux #(
    .WIDX_W (WIDX_W),
    .DATA_W (DATA_W),
    .CTRL_W (CTRL_W),
    .DIV_W  (DIV_W)
  ) u_mux (
    .widx      (widx),
    .ctrl      (ctrl_q),
    .cdiv      (cdiv_q),
    .stat      (stat),
    .pending   (pending),
    .hold      (hold),
    .last      (last),
    .id_hit    (id_hit),
    .rdata_nxt (rdata_nxt)
  );

  AST_TX_STROBE: assert property (@(posedge clk) disable iff (rst)
    wr_req && widx == WIDX_W'(W_DATA) |=> tx_valid && tx_data == $past(bus_wdata[7:0])); // R10
  AST_TX_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(wr_req && widx == WIDX_W'(W_DATA)) |=> !tx_valid); // R10
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[BIT_IRQ_ALWAYS] && !pending |-> !irq); // R7
  AST_ID_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_req && id_hit |=> bus_rdata[DATA_W-1:8] == '0); // R9
endmodule

// File: tb/sim_ps2_host_regs.sv
module sim_ps2_host_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, rx_busy = 1'b0;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_busy = 1'b0, line_clk = 1'b0, line_dat = 1'b0;
  logic        irq;

  int vectors = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_ctrl = 0, m_div = 0, m_last = 0, m_hold = 0;
  logic       m_pend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ps2_host_regs u0 (.*);

  function automatic logic [7:0] exp_id(input int k);
    logic [7:0] t [8] = '{8'h50, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[k];
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    int w = int'(a >> 2);
    if (w >= 1016) return {24'h0, exp_id(w - 1016)};
    case (w)
      0: return {24'h0, m_ctrl};
      1: return {25'h0, 1'b1, tx_busy, m_pend, rx_busy, ^m_last, line_clk, line_dat};
      2: return {24'h0, m_pend ? m_hold : m_last};
      3: return {24'h0, m_div};
      4: return {30'h0, 2'b11 & {1'b1, m_pend}};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return m_ctrl[3] || (m_ctrl[4] && m_pend);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [11:0] a, input string req);
    logic [31:0] e;
    e = exp_read(a);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_sel = 0;
    check(req, bus_rdata, e);
    if ((a >> 2) == 2 && m_pend) begin m_last = m_hold; m_pend = 0; end
    check("R3 ready", {31'h0, rx_ready}, {31'h0, !m_pend});
    check("R7 irq", {31'h0, irq}, {31'h0, exp_irq()});
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input string req);
    int w = int'(a >> 2);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    if (w == 0) m_ctrl = d[7:0];
    if (w == 3) m_div = d[7:0];
    check({req, " R10 valid"}, {31'h0, tx_valid}, {31'h0, w == 2});
    if (w == 2) check("R10 data", {24'h0, tx_data}, {24'h0, d[7:0]});
    check("R7 irq", {31'h0, irq}, {31'h0, exp_irq()});
  endtask

  task automatic rx_push(input logic [7:0] b);
    check("R3 ready before", {31'h0, rx_ready}, {31'h0, !m_pend});
    rx_valid = 1; rx_data = b;
    @(posedge clk); @(negedge clk);
    rx_valid = 0;
    if (!m_pend) begin m_hold = b; m_pend = 1; end
    check("R3 ready after", {31'h0, rx_ready}, {31'h0, !m_pend});
    check("R7 irq", {31'h0, irq}, {31'h0, exp_irq()});
  endtask

  function automatic logic [11:0] pick_addr();
    int r = $urandom_range(0, 9);
    case (r)
      0, 1: return 12'h008;
      2: return 12'h000;
      3: return 12'h004;
      4: return 12'h00C;
      5: return 12'h010;
      6: return 12'h014 + 12'(4 * $urandom_range(0, 8));
      7: return 12'hFE0 + 12'(4 * $urandom_range(0, 7));
      default: return 12'(4 * $urandom_range(0, 5));
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    check("R1 rdata", bus_rdata, 0);
    check("R1 ready", {31'h0, rx_ready}, 1);
    check("R1 irq", {31'h0, irq}, 0);
    check("R1 tx_valid", {31'h0, tx_valid}, 0);
    bus_read(12'h000, "R1 ctrl");
    bus_read(12'h00C, "R1 div");
    bus_read(12'h008, "R4 empty data read");
    bus_read(12'h010, "R8 istat");
    // R9 identification window
    for (int k = 0; k < 8; k++) bus_read(12'hFE0 + 12'(4 * k), "R9 id");
    // R2 storage
    bus_write(12'h000, 32'hFFFF_FF5A, "R2");
    bus_read(12'h000, "R2 ctrl");
    bus_write(12'h00C, 32'h1234_56A7, "R2");
    bus_read(12'h00C, "R2 div");
    bus_write(12'h000, 32'h0000_0010, "R7");
    // R3/R4 hold and pop, R6 parity
    rx_push(8'hA5);
    bus_read(12'h010, "R8 pending");
    rx_push(8'h3C);             // dropped: one already pending
    bus_read(12'h004, "R5 status");
    bus_read(12'h008, "R4 pop");
    bus_read(12'h008, "R4 repeat");
    bus_read(12'h004, "R6 parity even");
    rx_push(8'h01);
    bus_read(12'h008, "R4 pop2");
    tx_busy = 1; rx_busy = 1; line_clk = 1;
    bus_read(12'h004, "R6 parity odd");
    // R11 ignored writes
    bus_write(12'h004, 32'hFF, "R11 stat");
    bus_write(12'h010, 32'hFF, "R11 istat");
    bus_write(12'hFE8, 32'hFF, "R11 id");
    bus_write(12'h200, 32'hFF, "R11 unmapped");
    bus_read(12'h000, "R11 ctrl kept");
    bus_read(12'h00C, "R11 div kept");
    bus_read(12'hFE8, "R11 id kept");
    bus_read(12'h200, "R11 unmapped zero");
    bus_write(12'h008, 32'hDEAD_BE6B, "R10");
    bus_write(12'h000, 32'h08, "R7 always");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 9);
      tx_busy = 1'($urandom); rx_busy = 1'($urandom);
      line_clk = 1'($urandom); line_dat = 1'($urandom);
      if (op < 3) rx_push(8'($urandom));
      else if (op < 5) bus_write(pick_addr(), $urandom, "R2 rand");
      else bus_read(pick_addr(), "R5 rand");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule